// File: doc/BRIEF.md
# Synchronous PWM duty update sequencer

This block sits beside a PWM core whose channels share one period counter. A stream port (valid/ready, fed by a DMA engine) delivers 16-bit duty words. The block writes each word into the shadow register of the next channel in the synchronized group, always in ascending channel index order. Once every channel in the group has a word, it holds the stream off.

The block counts period-start pulses. On the pulse that completes an update interval of `UPR+1` periods, it copies the shadows of the group into the active duty registers and applies any pending new interval length. At that moment it rearms the channel pointer. If the group was not completely loaded in time, it flags an underrun. A ready flag and a one-cycle transfer request tell the DMA engine to send the next set. A mode bit raises them either at each commit or at each compare-match pulse.

Separately, a software unlock bit moves staged period and dead-time values into their active registers at the next period start. Four sticky or level status bits feed a masked interrupt. A status-read pulse clears the sticky bits.

Top module: `pwm_sync_update_seq`

## Requirements
- R1: A commit happens on the period-start pulse that is the (U+1)-th since reset or since the previous commit, where U is `upr_active`. On that edge, each channel selected in `sync_mask` loads its shadow value into its slice of `duty_active` (channel i at bits i*16 upward). The new value is visible after the edge. Earlier period starts leave `duty_active` unchanged.
- R2: Accepted stream words are written to the selected channels in ascending index order, skipping channels that are not selected. A channel that is not selected keeps its active duty value.
- R3: After every selected channel has received a word, `s_ready` stays low until a commit. It is also low in the commit cycle. After a commit, the next word goes to the lowest selected channel.
- R4: With `req_on_match` = 0, the ready flag (`status[0]`) is set by a commit. With `req_on_match` = 1, it is set by a `cmp_match` pulse instead, and a commit does not set it. `dma_req` pulses for one cycle, in the same cycle the flag becomes set.
- R5: A commit that occurs before all selected channels have been loaded sets the underrun flag (`status[3]`).
- R6: A `status_read` pulse clears `status[0]`, `status[1]` and `status[3]`. When a set event coincides with the read, the flag ends up set.
- R7: The transfer-complete flag (`status[1]`) is set when the last word of a set is accepted. The buffer-empty bit (`status[2]`) is high while the current set is complete and no further word is expected.
- R8: A value written via `upr_wr` takes effect at the next commit. The following interval then lasts the new value plus one periods.
- R9: An `unlock_set` pulse raises `unlock_pending`. On the next period start, `prd_new` and `dt_new` move to `prd_active` and `dt_active`, and `unlock_pending` clears.
- R10: `irq` is high exactly when some bit of `status` is high and the matching `irq_mask` bit is set.
- R11: After reset, the following are zero: `duty_active`, `upr_active`, `prd_active`, `dt_active`, `unlock_pending`, `dma_req`, `status` and `irq`. With a non-zero mask, `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mask | input | 4 | Channels in the synchronized group |
| req_on_match | input | 1 | 1: ready flag follows compare match; 0: follows commit |
| cmp_match | input | 1 | Compare-match pulse from the PWM core |
| period_start | input | 1 | Period-start pulse from the PWM core |
| s_valid | input | 1 | Duty stream valid |
| s_data | input | 16 | Duty stream word |
| s_ready | output | 1 | Duty stream ready |
| upr_new | input | 4 | Staged update-interval value |
| upr_wr | input | 1 | Write strobe for `upr_new` |
| prd_new | input | 16 | Staged period value |
| dt_new | input | 8 | Staged dead-time value |
| unlock_set | input | 1 | Request to apply staged period and dead time |
| status_read | input | 1 | Status read pulse (clears sticky flags) |
| irq_mask | input | 4 | Interrupt enable per status bit |
| duty_active | output | 64 | Active duty values, 16 bits per channel |
| upr_active | output | 4 | Active update-interval value |
| prd_active | output | 16 | Active period value |
| dt_active | output | 8 | Active dead-time value |
| unlock_pending | output | 1 | Unlock requested, not yet applied |
| dma_req | output | 1 | One-cycle transfer request |
| status | output | 4 | {underrun, buffer empty, transfer done, ready} |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets three timing corners:
- The commit edge. It checks that no commit happens on period U but only on period U+1. A counter off by one would move the duty values a period early.
- Words offered while the group is full. A design that does not hold them off would overwrite channel 0 or spill into an unselected channel. The scoreboard then sees a wrong duty vector.
- A status read in the same cycle as a set event. A design with clear-over-set priority would lose the ready flag.

The bench also checks the commit in which a new interval length takes over, the underrun on a short set in both request modes, and the unlock path at the next period start.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
   // Status bit positions (the interrupt mask uses the same layout)
   localparam int ST_RDY   = 0;
   localparam int ST_DONE  = 1;
   localparam int ST_EMPTY = 2;
   localparam int ST_UNDER = 3;
   localparam int ST_NUM   = 4;
endpackage

// File: rtl/pwm_sync_loader.sv
module pwm_sync_loader #(
   parameter int NCH = 4,
   parameter int DW  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    sel_mask,
   input  logic              in_valid,
   input  logic [DW-1:0]     in_data,
   output logic              in_ready,
   input  logic              commit,
   output logic              set_done,
   output logic              last_evt,
   output logic [NCH*DW-1:0] duty_flat
);
   logic [NCH-1:0] filled;
   logic [NCH-1:0] want;
   logic [NCH-1:0] pick;
   logic           take;

   // Remaining channels; the lowest one still wanted gets the next word
   assign want     = sel_mask & ~filled;
   assign pick     = want & (~want + 1'b1);
   assign set_done = (want == '0);
   assign in_ready = !set_done && !commit;
   assign take     = in_valid && in_ready;
   assign last_evt = take && ((want & ~pick) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      filled <= '0;
      else if (commit) filled <= '0;
      else if (take)   filled <= filled | pick;
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic [DW-1:0] shadow_q;
      logic [DW-1:0] active_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
         end else begin
            if (take && pick[ch])        shadow_q <= in_data;
            if (commit && sel_mask[ch]) active_q <= shadow_q;
         end
      end
      assign duty_flat[ch*DW +: DW] = active_q;
   end

   // R2: outside a commit, the fill mask only gains bits
   p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ((filled & $past(filled)) == $past(filled)));
   // R2: at most one channel is filled per cycle
   p_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($countones(filled ^ $past(filled)) <= 1));
   // R3: a commit rearms the pointer
   p_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (filled == '0));
endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer #(
   parameter int UPRW = 4,
   parameter int PW   = 16,
   parameter int DTW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            period_start,
   input  logic            upr_wr,
   input  logic [UPRW-1:0] upr_new,
   input  logic [PW-1:0]   prd_new,
   input  logic [DTW-1:0]  dt_new,
   input  logic            unlock_set,
   output logic            commit,
   output logic [UPRW-1:0] upr_active,
   output logic [PW-1:0]   prd_active,
   output logic [DTW-1:0]  dt_active,
   output logic            unlock_pending
);
   logic [UPRW-1:0] cnt;
   logic [UPRW-1:0] upr_hold;
   logic            upr_pend;

   assign commit = period_start && (cnt == upr_active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         upr_active <= '0;
         upr_hold   <= '0;
         upr_pend   <= 1'b0;
      end else begin
         if (period_start) cnt <= commit ? '0 : cnt + 1'b1;
         if (commit && upr_pend) begin
            upr_active <= upr_hold;
            upr_pend   <= 1'b0;
         end
         // a write in the commit cycle stays pending for the next interval
         if (upr_wr) begin
            upr_hold <= upr_new;
            upr_pend <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prd_active     <= '0;
         dt_active      <= '0;
         unlock_pending <= 1'b0;
      end else begin
         if (period_start && unlock_pending) begin
            prd_active <= prd_new;
            dt_active  <= dt_new;
         end
         unlock_pending <= unlock_set || (unlock_pending && !period_start);
      end
   end

   // R1: the period counter never passes the active interval value
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= upr_active);
   // R9: the pending unlock clears when applied, unless re-requested
   p_unlock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && unlock_pending) |=> (unlock_pending == $past(unlock_set)));
endmodule

// File: rtl/pwm_sync_status.sv
module pwm_sync_status
   import pwm_sync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy_evt,
   input  logic              done_evt,
   input  logic              under_evt,
   input  logic              empty_lvl,
   input  logic              st_read,
   input  logic [ST_NUM-1:0] irq_mask,
   output logic [ST_NUM-1:0] flags,
   output logic              irq,
   output logic              dma_req
);
   logic rdy_q, done_q, under_q;

   // Set takes priority over the read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q   <= 1'b0;
         done_q  <= 1'b0;
         under_q <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         rdy_q   <= rdy_evt   || (rdy_q   && !st_read);
         done_q  <= done_evt  || (done_q  && !st_read);
         under_q <= under_evt || (under_q && !st_read);
         dma_req <= rdy_evt;
      end
   end

   always_comb begin
      flags           = '0;
      flags[ST_RDY]   = rdy_q;
      flags[ST_DONE]  = done_q;
      flags[ST_EMPTY] = empty_lvl;
      flags[ST_UNDER] = under_q;
   end
   assign irq = |(flags & irq_mask);

   // R6: a set event coinciding with a read leaves the flag set
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_evt && st_read) |=> flags[ST_RDY]);
   // R4: the transfer request only appears together with the ready flag
   p_dma_with_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> flags[ST_RDY]);
endmodule

// File: rtl/pwm_sync_update_seq.sv
module pwm_sync_update_seq
   import pwm_sync_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int DW   = 16,
   parameter int UPRW = 4,
   parameter int PW   = 16,
   parameter int DTW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    sync_mask,
   input  logic              req_on_match,
   input  logic              cmp_match,
   input  logic              period_start,
   input  logic              s_valid,
   input  logic [DW-1:0]     s_data,
   output logic              s_ready,
   input  logic [UPRW-1:0]   upr_new,
   input  logic              upr_wr,
   input  logic [PW-1:0]     prd_new,
   input  logic [DTW-1:0]    dt_new,
   input  logic              unlock_set,
   input  logic              status_read,
   input  logic [ST_NUM-1:0] irq_mask,
   output logic [NCH*DW-1:0] duty_active,
   output logic [UPRW-1:0]   upr_active,
   output logic [PW-1:0]     prd_active,
   output logic [DTW-1:0]    dt_active,
   output logic              unlock_pending,
   output logic              dma_req,
   output logic [ST_NUM-1:0] status,
   output logic              irq
);
   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("NCH must be in 1..32");
   end
   if (DW < 1 || UPRW < 1 || PW < 1 || DTW < 1) begin : g_bad_width
      $error("all widths must be positive");
   end

   logic commit;
   logic set_done;
   logic last_evt;
   logic rdy_evt;

   pwm_sync_loader #(.NCH(NCH), .DW(DW)) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_mask (sync_mask),
      .in_valid (s_valid),
      .in_data  (s_data),
      .in_ready (s_ready),
      .commit   (commit),
      .set_done (set_done),
      .last_evt (last_evt),
      .duty_flat(duty_active)
   );

   pwm_sync_timer #(.UPRW(UPRW), .PW(PW), .DTW(DTW)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .period_start  (period_start),
      .upr_wr        (upr_wr),
      .upr_new       (upr_new),
      .prd_new       (prd_new),
      .dt_new        (dt_new),
      .unlock_set    (unlock_set),
      .commit        (commit),
      .upr_active    (upr_active),
      .prd_active    (prd_active),
      .dt_active     (dt_active),
      .unlock_pending(unlock_pending)
   );

   assign rdy_evt = req_on_match ? cmp_match : commit;

   pwm_sync_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_evt  (rdy_evt),
      .done_evt (last_evt),
      .under_evt(commit && !set_done),
      .empty_lvl(set_done),
      .st_read  (status_read),
      .irq_mask (irq_mask),
      .flags    (status),
      .irq      (irq),
      .dma_req  (dma_req)
   );

   // R5: a commit with an incomplete set leaves the underrun flag raised
   p_under_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !set_done) |=> status[ST_UNDER]);
   // R3: the stream is never ready while the set is complete
   p_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_EMPTY] |-> !s_ready);
endmodule

// File: tb/pwm_sync_update_seq_tb_top.sv
module pwm_sync_update_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int DW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      sync_mask = 4'b1011;
   logic            req_on_match = 1'b0, cmp_match = 1'b0, period_start = 1'b0;
   logic            s_valid = 1'b0;
   logic [15:0]     s_data = '0;
   logic            s_ready;
   logic [3:0]      upr_new = '0;
   logic            upr_wr = 1'b0;
   logic [15:0]     prd_new = '0;
   logic [7:0]      dt_new = '0;
   logic            unlock_set = 1'b0, status_read = 1'b0;
   logic [3:0]      irq_mask = '0;
   logic [63:0]     duty_active;
   logic [3:0]      upr_active;
   logic [15:0]     prd_active;
   logic [7:0]      dt_active;
   logic            unlock_pending, dma_req, irq;
   logic [3:0]      status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [63:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_sync_update_seq dut_i (
      .clk(clk), .rst_n(rst_n), .sync_mask(sync_mask), .req_on_match(req_on_match),
      .cmp_match(cmp_match), .period_start(period_start), .s_valid(s_valid),
      .s_data(s_data), .s_ready(s_ready), .upr_new(upr_new), .upr_wr(upr_wr),
      .prd_new(prd_new), .dt_new(dt_new), .unlock_set(unlock_set),
      .status_read(status_read), .irq_mask(irq_mask), .duty_active(duty_active),
      .upr_active(upr_active), .prd_active(prd_active), .dt_active(dt_active),
      .unlock_pending(unlock_pending), .dma_req(dma_req), .status(status), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: each change of the active duty vector must match the queue head
   initial begin
      logic [63:0] last = '0;
      forever begin
         @(negedge clk);
         if (rst_n && duty_active !== last) begin
            if (exp_q.size() == 0) chk("R1 unexpected duty change", duty_active, last);
            else chk("R1/R2 committed duty vector", duty_active, exp_q.pop_front());
            last = duty_active;
         end
      end
   end

   task automatic send_word(input logic [15:0] d);
      s_valid = 1'b1;
      s_data  = d;
      #1;
      while (!s_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
   endtask

   task automatic pulse_period();
      period_start = 1'b1;
      @(negedge clk);
      period_start = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R11: reset state
      chk("R11 duty", duty_active, 64'h0);
      chk("R11 status", {60'h0, status}, 64'h0);
      chk("R11 upr/unlock/dma/irq", {upr_active, unlock_pending, dma_req, irq}, 64'h0);
      chk("R11 s_ready", s_ready, 1);

      // R8 + R5 + R4: new interval staged, first commit with empty set
      upr_new = 4'd2; upr_wr = 1'b1;
      @(negedge clk);
      upr_wr = 1'b0;
      pulse_period();
      chk("R5 underrun on short set", status[3], 1);
      chk("R4 ready on commit", status[0], 1);
      chk("R4 dma_req pulse", dma_req, 1);
      chk("R8 new interval applied", upr_active, 4'd2);
      @(negedge clk);
      chk("R4 dma_req one cycle", dma_req, 0);

      // R6: read clears
      status_read = 1'b1;
      @(negedge clk);
      status_read = 1'b0;
      chk("R6 read clears", {60'h0, status}, 64'h0);

      // R2/R3/R7: load channels 0,1,3
      exp_q.push_back({16'hC3C3, 16'h0000, 16'hB2B2, 16'hA1A1});
      send_word(16'hA1A1);
      send_word(16'hB2B2);
      send_word(16'hC3C3);
      s_valid = 1'b1; s_data = 16'hD4D4;
      #1;
      chk("R3 ready low when full", s_ready, 0);
      chk("R7 done and empty", {62'h0, status[2:1]}, 64'h3);
      repeat (3) @(negedge clk);
      #1;
      chk("R3 still held off", s_ready, 0);

      // R1: no commit after U periods, commit on U+1
      pulse_period();
      pulse_period();
      chk("R1 no early commit", duty_active, 64'h0);
      pulse_period();
      chk("R5 no underrun on full set", status[3], 0);
      chk("R8 interval lasted U+1", duty_active, {16'hC3C3, 16'h0000, 16'hB2B2, 16'hA1A1});
      #1;
      chk("R3 ready after commit", s_ready, 1);
      @(negedge clk);
      s_valid = 1'b0;
      chk("R7 empty low after restart", status[2], 0);

      // R4/R6: match mode, set wins over read
      req_on_match = 1'b1;
      status_read = 1'b1;
      @(negedge clk);
      status_read = 1'b0;
      chk("R6 clear before match", {60'h0, status}, 64'h0);
      cmp_match = 1'b1; status_read = 1'b1;
      @(negedge clk);
      cmp_match = 1'b0; status_read = 1'b0;
      chk("R6 set wins over read", status[0], 1);
      chk("R4 dma_req on match", dma_req, 1);
      status_read = 1'b1;
      @(negedge clk);
      status_read = 1'b0;
      chk("R6 read clears ready", status[0], 0);

      // Commit in match mode with only channel 0 reloaded (restart at lowest: R3)
      exp_q.push_back({16'hC3C3, 16'h0000, 16'hB2B2, 16'hD4D4});
      pulse_period();
      pulse_period();
      pulse_period();
      chk("R5 underrun in match mode", status[3], 1);
      chk("R4 no ready on commit in match mode", status[0], 0);
      chk("R2 unselected channel unchanged", duty_active[47:32], 16'h0);

      // R10: masked interrupt
      irq_mask = 4'b0000; #1;
      chk("R10 masked off", irq, 0);
      irq_mask = 4'b1000; #1;
      chk("R10 underrun enabled", irq, 1);
      irq_mask = 4'b0001; #1;
      chk("R10 ready enabled only", irq, 0);

      // R9: unlock path
      @(negedge clk);
      prd_new = 16'h1234; dt_new = 8'h56; unlock_set = 1'b1;
      @(negedge clk);
      unlock_set = 1'b0;
      chk("R9 pending raised", unlock_pending, 1);
      chk("R9 not applied yet", prd_active, 16'h0);
      pulse_period();
      chk("R9 values applied", {prd_active, dt_active}, {16'h1234, 8'h56});
      chk("R9 pending cleared", unlock_pending, 0);

      repeat (2) @(negedge clk);
      chk("R1 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule